// File: doc/BRIEF.md
# Register-Mapped Clock-Tile Reconfiguration Bridge

This block puts a clock tile's dynamic reconfiguration port (DRP) behind a small set of memory-mapped registers, so that a processor on an AXI4-Lite style register bus can reconfigure the tile. Two plain configuration registers sit beside the DRP access path. The first drives a core enable pin and a tile enable pin. The second holds a clock-source select code.

Software starts a DRP transfer with one 32-bit control word. That word carries a start flag, a direction flag, the DRP register address and the write data. The bridge then runs one enable/ready handshake on the DRP side. A single status word shows busy, a sticky collision flag and the last data read. Software polls status until busy drops and takes the read data from that same word. If a control write arrives while a transfer is still running, the bridge refuses it and records the collision.

Top module: `drp_csr_bridge`

## Requirements
- R1: After reset, core_en, tile_en, clk_sel, drp_en and drp_we are 0, and reads of offsets 0x40, 0x44, 0x70 and 0x74 return 0.
- R2: Offset 0x40 is the enable register. A write sets core_en from bit 0 and tile_en from bit 1. A read returns both bits in those positions, and all other bits read as 0.
- R3: Offset 0x44 is the clock-select register. A write stores the low CLKSEL_W bits, drives them on clk_sel and reads them back unchanged. The upper bits read as 0.
- R4: Offset 0x70 is the control register. Bit 29 starts a transfer, bit 28 set means read and clear means write, bits 22:16 hold the DRP address and bits 15:0 hold the write data. A read returns the direction, address and data of the last started transfer. Bit 29 and bits 31:30 and 27:23 read as 0.
- R5: A control write with bit 29 set while idle starts a transfer. Busy is set from the next cycle. drp_en is high for exactly that one cycle, with drp_addr and drp_di taken from the word. drp_we is high with drp_en only for a write.
- R6: Offset 0x74 is the status register: bit 16 is busy and bits 15:0 are read data. Busy stays set until drp_rdy is sampled and clears on that edge. On a read transfer, drp_do is latched on that same edge. A write transfer leaves the read data unchanged.
- R7: A control write that arrives while busy is ignored: no new handshake starts and the running transfer is unchanged. It sets status bit 17. Bit 17 stays set until a status read, which returns it set and then clears it.
- R8: A control write with bit 29 clear while idle starts nothing and changes neither the control readback nor the status.
- R9: drp_rdy seen while idle has no effect on busy or on the read data.
- R10: Reads of unmapped offsets return 0, and writes to them change no register. Every write and read response is OKAY (00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address accepted |
| s_wdata | input | 32 | Write data |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data accepted |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response taken |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address accepted |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data taken |
| core_en | output | 1 | Core enable, enable register bit 0 |
| tile_en | output | 1 | Clock tile enable, enable register bit 1 |
| clk_sel | output | CLKSEL_W | Clock-source select code |
| drp_en | output | 1 | DRP enable, one cycle per transfer |
| drp_we | output | 1 | DRP write enable, high with drp_en on writes |
| drp_addr | output | DRP_ADDR_W | DRP register address |
| drp_di | output | DRP_DATA_W | DRP write data |
| drp_do | input | DRP_DATA_W | DRP read data, valid with drp_rdy |
| drp_rdy | input | 1 | DRP transfer done |

## Verification
The assertions assume that the DRP slave raises drp_rdy at most once per enable pulse, and never in the same cycle as that pulse. They also assume that ready pulses arriving while idle are stray events the bridge must discard. The bench's slave model answers each enable with a single ready pulse after a latency of one or more cycles, chosen per transfer. Between ready pulses it drives drp_do with a marker value, so data latched at the wrong edge shows up in the result. The stray idle ready used for R9 is injected on its own, only when no transfer is pending.

// File: rtl/drp_bridge_pkg.sv
package drp_bridge_pkg;

    localparam int unsigned BUS_W        = 32;

    localparam int unsigned OFS_ENABLE   = 32'h40;
    localparam int unsigned OFS_CLKSEL   = 32'h44;
    localparam int unsigned OFS_CONTROL  = 32'h70;
    localparam int unsigned OFS_STATUS   = 32'h74;

    localparam int unsigned CTL_GO_BIT   = 29;
    localparam int unsigned CTL_RD_BIT   = 28;
    localparam int unsigned CTL_ADR_LSB  = 16;

    localparam int unsigned ST_BUSY_BIT  = 16;
    localparam int unsigned ST_ERR_BIT   = 17;

    localparam logic [1:0]  RESP_OKAY    = 2'b00;

endpackage

// File: rtl/drp_axil_port.sv
module drp_axil_port
    import drp_bridge_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [BUS_W-1:0]  s_wdata,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [BUS_W-1:0]  s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic              wr_fire,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BUS_W-1:0]  wr_data,
    output logic              rd_fire,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [BUS_W-1:0]  rd_word
);

    typedef struct packed {
        logic             bvalid;
        logic             rvalid;
        logic [BUS_W-1:0] rdata;
    } port_t;

    port_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        wr_fire = s_awvalid && s_wvalid && !st_q.bvalid;
        rd_fire = s_arvalid && !st_q.rvalid;
        if (st_q.bvalid && s_bready) st_d.bvalid = 1'b0;
        if (wr_fire)                 st_d.bvalid = 1'b1;
        if (st_q.rvalid && s_rready) st_d.rvalid = 1'b0;
        if (rd_fire) begin
            st_d.rvalid = 1'b1;
            st_d.rdata  = rd_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign s_awready = wr_fire;
    assign s_wready  = wr_fire;
    assign s_bvalid  = st_q.bvalid;
    assign s_bresp   = RESP_OKAY;
    assign s_arready = !st_q.rvalid;
    assign s_rvalid  = st_q.rvalid;
    assign s_rdata   = st_q.rdata;
    assign s_rresp   = RESP_OKAY;
    assign wr_addr   = s_awaddr;
    assign wr_data   = s_wdata;
    assign rd_addr   = s_araddr;

endmodule

// File: rtl/drp_txn_ctrl.sv
module drp_txn_ctrl #(
    parameter int unsigned AW = 7,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_wr,
    input  logic          go,
    input  logic          rd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_data,
    input  logic          stat_rd,
    input  logic          drp_rdy,
    input  logic [DW-1:0] drp_do,
    output logic          drp_en,
    output logic          drp_we,
    output logic [AW-1:0] drp_addr,
    output logic [DW-1:0] drp_di,
    output logic          busy,
    output logic          err,
    output logic          last_rd,
    output logic [DW-1:0] rdata
);

    typedef struct packed {
        logic          busy;
        logic          en;
        logic          we;
        logic          err;
        logic          rd;
        logic [AW-1:0] addr;
        logic [DW-1:0] di;
        logic [DW-1:0] rdata;
    } txn_t;

    txn_t tx_d, tx_q;

    always_comb begin
        tx_d    = tx_q;
        tx_d.en = 1'b0;
        tx_d.we = 1'b0;
        if (tx_q.busy && drp_rdy) begin
            tx_d.busy = 1'b0;
            if (tx_q.rd) tx_d.rdata = drp_do;
        end
        if (stat_rd) tx_d.err = 1'b0;
        if (ctl_wr) begin
            if (tx_q.busy) begin
                tx_d.err = 1'b1;
            end else if (go) begin
                tx_d.busy = 1'b1;
                tx_d.en   = 1'b1;
                tx_d.we   = !rd_op;
                tx_d.rd   = rd_op;
                tx_d.addr = cmd_addr;
                tx_d.di   = cmd_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign drp_en   = tx_q.en;
    assign drp_we   = tx_q.we;
    assign drp_addr = tx_q.addr;
    assign drp_di   = tx_q.di;
    assign busy     = tx_q.busy;
    assign err      = tx_q.err;
    assign last_rd  = tx_q.rd;
    assign rdata    = tx_q.rdata;

endmodule

// File: rtl/drp_csr_bridge.sv
module drp_csr_bridge
    import drp_bridge_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned CLKSEL_W   = 2,
    parameter int unsigned DRP_ADDR_W = 7,
    parameter int unsigned DRP_DATA_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     s_awaddr,
    input  logic                  s_awvalid,
    output logic                  s_awready,
    input  logic [31:0]           s_wdata,
    input  logic                  s_wvalid,
    output logic                  s_wready,
    output logic [1:0]            s_bresp,
    output logic                  s_bvalid,
    input  logic                  s_bready,
    input  logic [ADDR_W-1:0]     s_araddr,
    input  logic                  s_arvalid,
    output logic                  s_arready,
    output logic [31:0]           s_rdata,
    output logic [1:0]            s_rresp,
    output logic                  s_rvalid,
    input  logic                  s_rready,
    output logic                  core_en,
    output logic                  tile_en,
    output logic [CLKSEL_W-1:0]   clk_sel,
    output logic                  drp_en,
    output logic                  drp_we,
    output logic [DRP_ADDR_W-1:0] drp_addr,
    output logic [DRP_DATA_W-1:0] drp_di,
    input  logic [DRP_DATA_W-1:0] drp_do,
    input  logic                  drp_rdy
);

    localparam logic [ADDR_W-1:0] A_ENABLE  = ADDR_W'(OFS_ENABLE);
    localparam logic [ADDR_W-1:0] A_CLKSEL  = ADDR_W'(OFS_CLKSEL);
    localparam logic [ADDR_W-1:0] A_CONTROL = ADDR_W'(OFS_CONTROL);
    localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(OFS_STATUS);

    typedef struct packed {
        logic                core_en;
        logic                tile_en;
        logic [CLKSEL_W-1:0] csel;
    } cfg_t;

    logic                  wr_fire, rd_fire;
    logic [ADDR_W-1:0]     wr_addr, rd_addr;
    logic [BUS_W-1:0]      wr_data, rd_word;
    logic                  ctl_wr, stat_rd;
    logic                  eng_busy, eng_err, eng_rd;
    logic [DRP_DATA_W-1:0] eng_rdata;
    logic                  wdata_unused;
    cfg_t                  cfg_d, cfg_q;

    drp_axil_port #(.ADDR_W(ADDR_W)) u_port (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
        .s_wdata(s_wdata), .s_wvalid(s_wvalid), .s_wready(s_wready),
        .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
        .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
        .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
        .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_fire(rd_fire), .rd_addr(rd_addr), .rd_word(rd_word)
    );

    assign ctl_wr       = wr_fire && (wr_addr == A_CONTROL);
    assign stat_rd      = rd_fire && (rd_addr == A_STATUS);
    assign wdata_unused = ^wr_data;

    drp_txn_ctrl #(.AW(DRP_ADDR_W), .DW(DRP_DATA_W)) u_txn (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr(ctl_wr),
        .go(wr_data[CTL_GO_BIT]),
        .rd_op(wr_data[CTL_RD_BIT]),
        .cmd_addr(wr_data[CTL_ADR_LSB +: DRP_ADDR_W]),
        .cmd_data(wr_data[DRP_DATA_W-1:0]),
        .stat_rd(stat_rd),
        .drp_rdy(drp_rdy), .drp_do(drp_do),
        .drp_en(drp_en), .drp_we(drp_we),
        .drp_addr(drp_addr), .drp_di(drp_di),
        .busy(eng_busy), .err(eng_err), .last_rd(eng_rd), .rdata(eng_rdata)
    );

    always_comb begin
        cfg_d = cfg_q;
        if (wr_fire && wr_addr == A_ENABLE) begin
            cfg_d.core_en = wr_data[0];
            cfg_d.tile_en = wr_data[1];
        end
        if (wr_fire && wr_addr == A_CLKSEL) cfg_d.csel = wr_data[CLKSEL_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rd_word = '0;
        if (rd_addr == A_ENABLE) begin
            rd_word[0] = cfg_q.core_en;
            rd_word[1] = cfg_q.tile_en;
        end else if (rd_addr == A_CLKSEL) begin
            rd_word[CLKSEL_W-1:0] = cfg_q.csel;
        end else if (rd_addr == A_CONTROL) begin
            rd_word[CTL_RD_BIT]                = eng_rd;
            rd_word[CTL_ADR_LSB +: DRP_ADDR_W] = drp_addr;
            rd_word[DRP_DATA_W-1:0]            = drp_di;
        end else if (rd_addr == A_STATUS) begin
            rd_word[ST_ERR_BIT]     = eng_err;
            rd_word[ST_BUSY_BIT]    = eng_busy;
            rd_word[DRP_DATA_W-1:0] = eng_rdata;
        end
    end

    assign core_en = cfg_q.core_en;
    assign tile_en = cfg_q.tile_en;
    assign clk_sel = cfg_q.csel;

endmodule

module drp_csr_bridge_chk #(
    parameter int unsigned DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          drp_en,
    input logic          drp_we,
    input logic          drp_rdy,
    input logic          busy,
    input logic          err,
    input logic          status_rd,
    input logic [DW-1:0] rdata
);

    p_en_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        drp_en |=> !drp_en);

    p_we_with_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        drp_we |-> drp_en);

    p_en_while_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        drp_en |-> busy);

    p_hold_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !drp_rdy) |=> busy);

    p_ready_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && drp_rdy) |=> !busy);

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !status_rd) |=> err);

    p_idle_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !drp_en) |=> $stable(rdata));

endmodule

bind drp_csr_bridge drp_csr_bridge_chk #(.DW(DRP_DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .drp_en(drp_en), .drp_we(drp_we), .drp_rdy(drp_rdy),
    .busy(eng_busy), .err(eng_err), .status_rd(stat_rd), .rdata(eng_rdata)
);

// File: tb/drp_csr_bridge_tb.sv
`timescale 1ns/1ps
module drp_csr_bridge_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  s_awaddr = '0, s_araddr = '0;
    logic        s_awvalid = 1'b0, s_wvalid = 1'b0, s_arvalid = 1'b0;
    logic [31:0] s_wdata = '0;
    logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
    logic [1:0]  s_bresp, s_rresp;
    logic [31:0] s_rdata;
    logic        core_en, tile_en, drp_en, drp_we;
    logic [1:0]  clk_sel;
    logic [6:0]  drp_addr;
    logic [15:0] drp_di;
    logic [15:0] drp_do = 16'hDEAD;
    logic        drp_rdy = 1'b0;

    int errors = 0;
    int checks = 0;
    int en_cnt = 0;
    int lat = 1;
    bit inj = 1'b0;

    always #2.5 clk = ~clk;

    drp_csr_bridge u_dut (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
        .s_wdata(s_wdata), .s_wvalid(s_wvalid), .s_wready(s_wready),
        .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(1'b1),
        .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
        .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(1'b1),
        .core_en(core_en), .tile_en(tile_en), .clk_sel(clk_sel),
        .drp_en(drp_en), .drp_we(drp_we), .drp_addr(drp_addr), .drp_di(drp_di),
        .drp_do(drp_do), .drp_rdy(drp_rdy)
    );

    // DRP slave model: register file with per-transfer ready latency
    initial begin
        logic [15:0] mem [128];
        logic [15:0] rdval;
        int cnt;
        bit pend;
        pend = 1'b0; cnt = 0; rdval = '0;
        for (int i = 0; i < 128; i++) mem[i] = '0;
        forever begin
            @(negedge clk);
            drp_rdy = 1'b0;
            drp_do  = 16'hDEAD;
            if (inj) begin
                drp_rdy = 1'b1; drp_do = 16'hBEEF; inj = 1'b0;
            end else if (pend) begin
                if (cnt == 0) begin drp_rdy = 1'b1; drp_do = rdval; pend = 1'b0; end
                else cnt--;
            end
            if (drp_en) begin
                en_cnt++;
                pend = 1'b1;
                cnt  = lat - 1;
                if (drp_we) mem[drp_addr] = drp_di;
                rdval = mem[drp_addr];
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        s_awaddr = a; s_wdata = d; s_awvalid = 1'b1; s_wvalid = 1'b1;
        #1;
        while (!s_awready) begin @(negedge clk); #1; end
        @(negedge clk);
        s_awvalid = 1'b0; s_wvalid = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        s_araddr = a; s_arvalid = 1'b1;
        #1;
        while (!s_arready) begin @(negedge clk); #1; end
        @(negedge clk);
        s_arvalid = 1'b0;
        d = s_rdata;
    endtask

    task automatic wait_idle(output logic [31:0] st);
        st = 32'h0001_0000;
        for (int i = 0; i < 100 && st[16]; i++) bus_rd(8'h74, st);
    endtask

    // {read, addr[6:0], data[15:0], latency[3:0]}
    localparam logic [27:0] VEC [8] = '{
        {1'b0, 7'h05, 16'hAAAA, 4'd1},
        {1'b0, 7'h7F, 16'h1234, 4'd3},
        {1'b1, 7'h05, 16'h0000, 4'd2},
        {1'b1, 7'h7F, 16'h0000, 4'd7},
        {1'b0, 7'h00, 16'hFFFF, 4'd1},
        {1'b1, 7'h00, 16'h0000, 4'd4},
        {1'b0, 7'h05, 16'h0001, 4'd5},
        {1'b1, 7'h05, 16'h0000, 4'd1}
    };

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] shadow [128];
        logic [31:0] r;
        logic [15:0] last_rd;
        int n0;
        for (int i = 0; i < 128; i++) shadow[i] = '0;
        last_rd = '0;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 outputs", {27'd0, core_en, tile_en, clk_sel, drp_en}, 32'd0);
        chk("R1 drp_we", {31'd0, drp_we}, 32'd0);
        bus_rd(8'h40, r); chk("R1 enable reg", r, 32'd0);
        bus_rd(8'h44, r); chk("R1 clksel reg", r, 32'd0);
        bus_rd(8'h70, r); chk("R1 control reg", r, 32'd0);
        bus_rd(8'h74, r); chk("R1 status reg", r, 32'd0);

        // R2 enable register
        bus_wr(8'h40, 32'hFFFF_FFFF);
        chk("R2 pins both", {30'd0, tile_en, core_en}, 32'd3);
        bus_rd(8'h40, r); chk("R2 readback", r, 32'd3);
        bus_wr(8'h40, 32'h0000_0002);
        chk("R2 pins tile only", {30'd0, tile_en, core_en}, 32'd2);

        // R3 clock select
        bus_wr(8'h44, 32'hFFFF_FFFD);
        chk("R3 clk_sel pin", {30'd0, clk_sel}, 32'd1);
        bus_rd(8'h44, r); chk("R3 readback", r, 32'd1);

        // R10 unmapped offsets, OKAY responses
        bus_wr(8'h48, 32'hFFFF_FFFF);
        chk("R10 bresp", {29'd0, s_bvalid, s_bresp}, 32'd4);
        bus_rd(8'h48, r); chk("R10 unmapped read", r, 32'd0);
        chk("R10 rresp", {30'd0, s_rresp}, 32'd0);
        bus_rd(8'h44, r); chk("R10 clksel untouched", r, 32'd1);
        bus_rd(8'h40, r); chk("R10 enable untouched", r, 32'd2);

        // R5 R6 vector table
        for (int v = 0; v < 8; v++) begin
            logic        vrd;
            logic [6:0]  va;
            logic [15:0] vd;
            {vrd, va, vd} = VEC[v][27:4];
            lat = int'(VEC[v][3:0]);
            n0 = en_cnt;
            bus_wr(8'h70, {2'b00, 1'b1, vrd, 5'd0, va, vd});
            chk("R5 enable pulse", {31'd0, drp_en}, 32'd1);
            chk("R5 we follows direction", {31'd0, drp_we}, {31'd0, ~vrd});
            chk("R5 address and data", {9'd0, drp_addr, drp_di}, {9'd0, va, vd});
            @(negedge clk);
            chk("R5 enable one cycle", {31'd0, drp_en}, 32'd0);
            wait_idle(r);
            chk("R6 busy cleared", {31'd0, r[16]}, 32'd0);
            chk("R5 single handshake", en_cnt - n0, 1);
            if (vrd) begin
                last_rd = shadow[va];
                chk("R6 read data latched", r, {16'd0, last_rd});
            end else begin
                shadow[va] = vd;
                chk("R6 write keeps read data", r, {16'd0, last_rd});
            end
        end

        // R4 control readback with all bits written
        lat = 2;
        bus_wr(8'h70, 32'hFFFF_FFFF);
        wait_idle(r);
        chk("R6 read of 0x7F", r, {16'd0, shadow[7'h7F]});
        last_rd = shadow[7'h7F];
        bus_rd(8'h70, r); chk("R4 control readback", r, 32'h107F_FFFF);

        // R8 control write without start
        n0 = en_cnt;
        bus_wr(8'h70, 32'h0012_5555);
        repeat (4) @(negedge clk);
        chk("R8 no handshake", en_cnt - n0, 0);
        bus_rd(8'h70, r); chk("R8 control unchanged", r, 32'h107F_FFFF);
        bus_rd(8'h74, r); chk("R8 status unchanged", r, {16'd0, last_rd});

        // R9 stray ready while idle
        inj = 1'b1;
        repeat (3) @(negedge clk);
        bus_rd(8'h74, r); chk("R9 idle ready ignored", r, {16'd0, last_rd});

        // R7 collision while busy
        lat = 20;
        n0 = en_cnt;
        bus_wr(8'h70, {2'b00, 1'b1, 1'b0, 5'd0, 7'h10, 16'hAAAA});
        bus_wr(8'h70, {2'b00, 1'b1, 1'b0, 5'd0, 7'h10, 16'h5555});
        bus_rd(8'h74, r); chk("R7 err and busy set", {30'd0, r[17:16]}, 32'd3);
        bus_rd(8'h74, r); chk("R7 err cleared by read", {31'd0, r[17]}, 32'd0);
        bus_rd(8'h70, r); chk("R7 running command kept", r, {16'h0010, 16'hAAAA});
        wait_idle(r);
        chk("R7 one handshake", en_cnt - n0, 1);
        lat = 3;
        bus_wr(8'h70, {2'b00, 1'b1, 1'b1, 5'd0, 7'h10, 16'h0000});
        wait_idle(r);
        chk("R7 ignored write not applied", r, 32'h0000_AAAA);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule